// File: doc/BRIEF.md
# Clock Enable Divider with Source Selection

This block derives two kinds of timing enables from a single input clock: a system enable and a PWM timing enable, the latter delivered identically to two PWM units. Each output is a one-cycle pulse synchronous to the input clock, so downstream logic runs on the input clock and uses the pulse as a clock enable. No real clock net is produced.

Two control words set the behaviour through a simple write strobe and a combinational read port. The primary word holds these fields:

- the system divider enable;
- the PWM divider enable and a 3-bit PWM divisor code;
- a PLL-select flag and a PLL power-down flag;
- the primary system divisor.

The alternate word holds an override flag and its own system divisor. When the PLL is selected and powered, the system divider is used even if its enable bit is clear. The PWM divisor code saturates at divide-by-64. Writing a word restarts the counters that depend on it, so a change of divisor takes effect at once.

Top module: `clk_en_div`

## Requirements
- R1: After reset, the primary word (address 0) reads 0x005C and the alternate word (address 1) reads 0x0000. The PWM code resets to 7, the PLL power-down flag (bit 6) to 1, and every other field to 0.
- R2: Primary word layout: bit 0 is the system divider enable, bit 1 the PWM divider enable, bits 4:2 the PWM code, bit 5 the PLL select, bit 6 the PLL power-down, and bits 11:8 the system divisor. Alternate word layout: bit 0 is the override flag and bits 4:1 the alternate divisor. Written fields read back; all other bits are reserved and read 0.
- R3: When the system divider is inactive, sys_en is 1 on every cycle.
- R4: When the system divider is active with divisor value N, sys_en pulses once every N+1 cycles. N=0 gives a pulse on every cycle.
- R5: With PLL select at 1 and power-down at 0, the system divider is active even when its enable bit is 0.
- R6: While the power-down bit is 1, the PLL select flag has no effect on sys_en.
- R7: When the override flag is 1, the divisor N comes from the alternate divisor instead of the primary one.
- R8: When the PWM divider enable is 0, pwm_en0 and pwm_en1 are 1 on every cycle.
- R9: When the PWM divider enable is 1, the PWM enable pulses once every 2^(c+1) cycles for code c from 0 to 4. Codes 5, 6 and 7 all give once every 64 cycles.
- R10: pwm_en0 and pwm_en1 are equal on every cycle.
- R11: A write to the primary word sets both counters to zero on the next cycle, and a write to the alternate word sets the system counter to zero. The first pulse after a write therefore comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 primary, 1 alternate |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read target: 0 primary, 1 alternate |
| rd_data | output | 16 | Read-back of the selected word |
| sys_en | output | 1 | System clock enable pulse |
| pwm_en0 | output | 1 | PWM unit 0 timing enable |
| pwm_en1 | output | 1 | PWM unit 1 timing enable |

## Verification
The hardest case to reach is the phase of the pulse trains right after a divisor change. The new period has to start from the write, not from wherever the old, longer count had reached. The bench reprograms both words in back-to-back cycles while long divisors are still counting. The scoreboard then predicts every cycle of both trains from the two write edges, with the PWM trains one cycle ahead of the system train. Other configurations pair a selected PLL with a powered-down PLL, and a primary divisor with an alternate override. These show the forced and the ignored source selection as different pulse spacings.

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int DW  = 16,
  parameter int SDW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sys_en,
  output logic          pwm_en0,
  output logic          pwm_en1
);
  localparam int B_SEN  = 0;
  localparam int B_PEN  = 1;
  localparam int B_PC   = 2;
  localparam int B_PSEL = 5;
  localparam int B_POFF = 6;
  localparam int B_SDIV = 8;
  localparam int PCW    = 6;

  logic           sdiv_en, pdiv_en, pll_sel, pll_off, alt_use;
  logic [2:0]     pcode;
  logic [SDW-1:0] sdiv, alt_div, sys_n, sys_cnt;
  logic [PCW-1:0] pwm_cnt, pwm_top;
  logic [2:0]     pcode_sat;
  logic           sys_act, wr_pri, wr_alt;

  assign wr_pri    = wr_en && !wr_addr;
  assign wr_alt    = wr_en &&  wr_addr;
  assign sys_act   = sdiv_en || (pll_sel && !pll_off);
  assign sys_n     = alt_use ? alt_div : sdiv;
  assign pcode_sat = (pcode > 3'd5) ? 3'd5 : pcode;
  assign pwm_top   = PCW'((7'd1 << (pcode_sat + 3'd1)) - 7'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdiv_en <= 1'b0;
      pdiv_en <= 1'b0;
      pcode   <= 3'd7;
      pll_sel <= 1'b0;
      pll_off <= 1'b1;
      sdiv    <= '0;
      alt_use <= 1'b0;
      alt_div <= '0;
    end else if (wr_pri) begin
      sdiv_en <= wr_data[B_SEN];
      pdiv_en <= wr_data[B_PEN];
      pcode   <= wr_data[B_PC +: 3];
      pll_sel <= wr_data[B_PSEL];
      pll_off <= wr_data[B_POFF];
      sdiv    <= wr_data[B_SDIV +: SDW];
    end else if (wr_alt) begin
      alt_use <= wr_data[0];
      alt_div <= wr_data[1 +: SDW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en || sys_cnt >= sys_n) sys_cnt <= '0;
    else                                     sys_cnt <= sys_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_pri || pwm_cnt >= pwm_top) pwm_cnt <= '0;
    else                                        pwm_cnt <= pwm_cnt + 1'b1;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data[0]        = alt_use;
      rd_data[1 +: SDW] = alt_div;
    end else begin
      rd_data[B_SEN]        = sdiv_en;
      rd_data[B_PEN]        = pdiv_en;
      rd_data[B_PC +: 3]    = pcode;
      rd_data[B_PSEL]       = pll_sel;
      rd_data[B_POFF]       = pll_off;
      rd_data[B_SDIV +: SDW] = sdiv;
    end
  end

  assign sys_en  = !sys_act || (sys_cnt == sys_n);
  assign pwm_en0 = !pdiv_en || (pwm_cnt == pwm_top);
  assign pwm_en1 = !pdiv_en || (pwm_cnt == pwm_top);
endmodule

module clk_en_div_chk #(
  parameter int DW  = 16,
  parameter int SDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           wr_addr,
  input logic           rd_addr,
  input logic [DW-1:0]  rd_data,
  input logic           sys_en,
  input logic           pwm_en0,
  input logic           pwm_en1,
  input logic           sdiv_en,
  input logic           pll_off,
  input logic [SDW-1:0] sys_cnt,
  input logic [SDW-1:0] sys_n,
  input logic [5:0]     pwm_cnt
);
  logic [DW-1:0] rsv_pri, rsv_alt;
  assign rsv_pri = ~(DW'(32'h0000_007F) | (DW'((1 << SDW) - 1) << 8));
  assign rsv_alt = ~DW'((1 << (SDW + 1)) - 1);

  a_r10_pwm_match: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en0 == pwm_en1);
  a_r11_pri_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> (pwm_cnt == 6'd0 && sys_cnt == '0));
  a_r11_alt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> sys_cnt == '0);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sys_cnt <= sys_n);
  a_r6_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_off && !sdiv_en) |-> sys_en);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & (rd_addr ? rsv_alt : rsv_pri)) == '0);
endmodule

bind clk_en_div clk_en_div_chk #(.DW(DW), .SDW(SDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .sys_en(sys_en),
  .pwm_en0(pwm_en0), .pwm_en1(pwm_en1), .sdiv_en(sdiv_en),
  .pll_off(pll_off), .sys_cnt(sys_cnt), .sys_n(sys_n), .pwm_cnt(pwm_cnt)
);

// File: tb/tb_clk_en_div.sv
module tb_clk_en_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [15:0] rd_data;
  logic        sys_en, pwm_en0, pwm_en1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  s;
    logic  p;
    string ts;
    string tp;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  clk_en_div dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_en(sys_en), .pwm_en0(pwm_en0), .pwm_en1(pwm_en1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_chk(input logic a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  function automatic logic [15:0] pri(input bit sen, input bit pen, input int code,
                                      input bit psel, input bit poff, input int n);
    return 16'(sen) | (16'(pen) << 1) | (16'(code) << 2) | (16'(psel) << 5)
         | (16'(poff) << 6) | (16'(n) << 8);
  endfunction

  // Drives both words on back-to-back edges and queues the expected pulse trains.
  task automatic run_cfg(input bit sen, input bit pen, input int code, input bit psel,
                         input bit poff, input int n, input bit au, input int an,
                         input string ts, input string tp, input int ncyc);
    int neff, pd;
    bit act;
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = pri(sen, pen, code, psel, poff, n);
    @(negedge clk);
    wr_addr = 1'b1; wr_data = 16'((an << 1) | int'(au));
    @(negedge clk);
    wr_en = 1'b0;
    act  = sen || (psel && !poff);
    neff = au ? an : n;
    pd   = 1 << ((code > 5 ? 5 : code) + 1);
    for (int i = 0; i < ncyc; i++) begin
      e.s  = !act || ((i % (neff + 1)) == neff);
      e.p  = !pen || (((i + 1) % pd) == pd - 1);
      e.ts = ts;
      e.tp = tp;
      q.push_back(e);
    end
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(sys_en == e.s, e.ts, sys_en, e.s);
        check(pwm_en0 == e.p, e.tp, pwm_en0, e.p);
        check(pwm_en1 == pwm_en0, "R10", pwm_en1, pwm_en0);
      end
    end
  end

  initial begin : watchdog
    #(20 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_chk(1'b0, 16'h005C, "R1");
    read_chk(1'b1, 16'h0000, "R1");
    // Default state: both divided paths off, every cycle enabled (R3, R8).
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2;
      check(sys_en == 1'b1, "R3", sys_en, 1);
      check(pwm_en0 == 1'b1 && pwm_en1 == 1'b1, "R8", pwm_en0, 1);
    end
    // Reserved bits mask to zero (R2).
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = 16'hFFFF;
    @(negedge clk); wr_addr = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    read_chk(1'b0, 16'h0F7F, "R2");
    read_chk(1'b1, 16'h001F, "R2");
    read_chk(1'b0, 16'h0F7F, "R2");

    run_cfg(1, 1, 0, 0, 1, 3, 0, 0, "R4", "R9", 40);
    run_cfg(1, 1, 1, 0, 1, 0, 0, 0, "R4", "R9", 20);
    run_cfg(0, 1, 2, 1, 0, 2, 0, 0, "R5", "R9", 40);
    run_cfg(0, 1, 4, 1, 1, 5, 0, 0, "R6", "R9", 70);
    run_cfg(1, 1, 6, 0, 1, 6, 1, 1, "R7", "R9", 140);
    run_cfg(1, 1, 7, 0, 1, 12, 1, 9, "R7", "R9", 140);
    // Short divisors written while long counts run: restart (R11).
    run_cfg(1, 1, 5, 0, 1, 2, 0, 0, "R11", "R11", 140);
    run_cfg(0, 0, 3, 0, 0, 7, 0, 0, "R3", "R8", 20);
    read_chk(1'b0, pri(0, 0, 3, 0, 0, 7), "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule